// File: doc/BRIEF.md
# GPIO Event Detector with Interrupt

This block watches a 32-bit vector of pin input values and records per-pin events in a sticky status register. Software chooses for each pin whether an event is a high level, a rising edge, or any change of value. Events stay recorded until software writes a one to the matching status bit. A per-pin enable mask, with its own set and clear aliases, selects which recorded events raise the single interrupt line.

A small register port (write strobe, byte address, write data, read data that follows the address in the same cycle) gives software access to the configuration, the mask and the status. Register writes take effect at the clock edge that samples them. Input changes are sampled on each clock edge. A previous-value register keeps the input seen one cycle earlier, and the edge modes compare against it.

Top module: `gpio_evt_top`

## Requirements
- R1: After reset, every register reads zero and `irqOut` is low.
- R2: A pin with mode bit 0 (mode register, offset 0x28) is level-sensitive. While its input is high, its status bit (offset 0x4C) is set on the next clock edge. The bit stays set after the input returns low.
- R3: A pin with mode bit 1 and any-edge bit 0 (offset 0x2C) sets its status only on a 0-to-1 change of its input. A 1-to-0 change leaves its status unchanged.
- R4: A pin with mode bit 1 and any-edge bit 1 sets its status on both a 0-to-1 and a 1-to-0 change.
- R5: Writing the status offset clears each status bit whose write-data bit is 1. Bits written with 0 are left as they were.
- R6: When a status clear and a new detection hit the same bit in the same cycle, the bit stays set. A level pin whose input is still high therefore cannot be cleared.
- R7: `irqOut` is high exactly when some bit is set in both the status and the enable mask (offset 0x40). It follows a register write by one clock edge. Removing only the input of a level event does not lower it.
- R8: A write to offset 0x44 ORs the write data into the enable mask. A write to offset 0x48 clears the mask bits that are 1 in the write data. Both offsets read back the mask.
- R9: The mode and any-edge registers read back what was written. Reads of unmapped offsets return zero. Writes to unmapped offsets change no register.
- R10: The previous-value register loads the input every cycle and resets to zero. Switching a steady input into an edge mode records no event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| dataIn | input | 32 | Per-pin input values to watch |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 7 | Register byte offset |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for `regAddr` |
| irqOut | output | 1 | Interrupt, high while any enabled status bit is set |

## Verification
Input vectors go high, then low, then mixed, on pins set to level, rising-only and any-edge modes. Comparing the three modes separates a design that latches levels from one that detects edges, and a rising detector from one that also reacts to falling inputs. Clears are written both while a level input is still high and after it has dropped, to tell "detection wins" from a plain clear. Enable set and clear writes are made while an event is pending, to show that the interrupt follows the mask on the next edge and drops only when the status bit is cleared.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;

  localparam int ADDR_W = 7;

  // Register byte offsets decoded by the bus side
  localparam logic [ADDR_W-1:0] OFS_MODE   = 7'h28;
  localparam logic [ADDR_W-1:0] OFS_ANYEDG = 7'h2C;
  localparam logic [ADDR_W-1:0] OFS_MASK   = 7'h40;
  localparam logic [ADDR_W-1:0] OFS_MSET   = 7'h44;
  localparam logic [ADDR_W-1:0] OFS_MCLR   = 7'h48;
  localparam logic [ADDR_W-1:0] OFS_STAT   = 7'h4C;

  // Write strobes from control to datapath
  typedef struct packed {
    logic wrMode;
    logic wrAnyEdge;
    logic wrMask;
    logic setMask;
    logic clrMask;
    logic clrStat;
  } evtStrobes_t;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_MODE,
    RD_ANYEDGE,
    RD_MASK,
    RD_STAT
  } rdSel_t;

endpackage

// File: rtl/gpio_evt_ctrl.sv
module gpio_evt_ctrl
  import gpio_evt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  output evtStrobes_t       stb,
  output rdSel_t            rdSel
);

  always_comb begin
    stb = '0;
    if (regWrEn) begin
      unique case (regAddr)
        OFS_MODE:   stb.wrMode    = 1'b1;
        OFS_ANYEDG: stb.wrAnyEdge = 1'b1;
        OFS_MASK:   stb.wrMask    = 1'b1;
        OFS_MSET:   stb.setMask   = 1'b1;
        OFS_MCLR:   stb.clrMask   = 1'b1;
        OFS_STAT:   stb.clrStat   = 1'b1;
        default:    stb           = '0;
      endcase
    end
  end

  always_comb begin
    unique case (regAddr)
      OFS_MODE:   rdSel = RD_MODE;
      OFS_ANYEDG: rdSel = RD_ANYEDGE;
      OFS_MASK,
      OFS_MSET,
      OFS_MCLR:   rdSel = RD_MASK;
      OFS_STAT:   rdSel = RD_STAT;
      default:    rdSel = RD_NONE;
    endcase
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb)); // R9

  AST_STROBE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !regWrEn |-> (stb == '0)); // R9

endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dataIn,
  input  logic [WIDTH-1:0] modeQ,
  input  logic [WIDTH-1:0] anyEdgeQ,
  output logic [WIDTH-1:0] hitVec
);

  logic [WIDTH-1:0] prevIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevIn <= '0;
    else       prevIn <= dataIn;
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic riseHit;
    logic anyHit;
    assign riseHit = dataIn[i] & ~prevIn[i];
    assign anyHit  = dataIn[i] ^ prevIn[i];

    always_comb begin
      if (!modeQ[i])         hitVec[i] = dataIn[i];
      else if (anyEdgeQ[i])  hitVec[i] = anyHit;
      else                   hitVec[i] = riseHit;
    end

    AST_NO_FALL_HIT: assert property (@(posedge clk) disable iff (!rstN)
      (modeQ[i] && !anyEdgeQ[i] && !dataIn[i]) |-> !hitVec[i]); // R3

    AST_STEADY_NO_EDGE: assert property (@(posedge clk) disable iff (!rstN)
      (modeQ[i] && $stable(dataIn[i])) |=> (!modeQ[i] || (dataIn[i] != $past(dataIn[i])) || !hitVec[i])); // R10
  end

endmodule

// File: rtl/gpio_evt_datapath.sv
module gpio_evt_datapath
  import gpio_evt_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  evtStrobes_t      stb,
  input  rdSel_t           rdSel,
  input  logic [WIDTH-1:0] wrData,
  input  logic [WIDTH-1:0] hitVec,
  output logic [WIDTH-1:0] modeQ,
  output logic [WIDTH-1:0] anyEdgeQ,
  output logic [WIDTH-1:0] rdData,
  output logic             irqOut
);

  logic [WIDTH-1:0] maskQ;
  logic [WIDTH-1:0] statQ;
  logic [WIDTH-1:0] clrVec;
  logic [WIDTH-1:0] maskNext;

  assign clrVec = stb.clrStat ? wrData : '0;

  always_comb begin
    maskNext = maskQ;
    if (stb.wrMask)  maskNext = wrData;
    if (stb.setMask) maskNext = maskQ | wrData;
    if (stb.clrMask) maskNext = maskQ & ~wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ    <= '0;
      anyEdgeQ <= '0;
      maskQ    <= '0;
      statQ    <= '0;
    end else begin
      if (stb.wrMode)    modeQ    <= wrData;
      if (stb.wrAnyEdge) anyEdgeQ <= wrData;
      maskQ <= maskNext;
      // new detection takes precedence over a clear of the same bit
      statQ <= (statQ & ~clrVec) | hitVec;
    end
  end

  assign irqOut = |(statQ & maskQ);

  always_comb begin
    unique case (rdSel)
      RD_MODE:    rdData = modeQ;
      RD_ANYEDGE: rdData = anyEdgeQ;
      RD_MASK:    rdData = maskQ;
      RD_STAT:    rdData = statQ;
      default:    rdData = '0;
    endcase
  end

  AST_STICKY_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    !stb.clrStat |=> ((statQ & $past(statQ)) == $past(statQ))); // R2

  AST_HIT_CAPTURED: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((statQ & $past(hitVec)) == $past(hitVec))); // R6

  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rstN)
    stb.setMask |=> ((maskQ & $past(wrData)) == $past(wrData))); // R8

  AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rstN)
    stb.clrMask |=> ((maskQ & $past(wrData)) == '0)); // R8

  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> ((statQ != '0) && (maskQ != '0))); // R7

endmodule

// File: rtl/gpio_evt_top.sv
module gpio_evt_top
  import gpio_evt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [31:0]       dataIn,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic              irqOut
);

  localparam int WIDTH = 32;

  evtStrobes_t      stb;
  rdSel_t           rdSel;
  logic [WIDTH-1:0] modeQ;
  logic [WIDTH-1:0] anyEdgeQ;
  logic [WIDTH-1:0] hitVec;

  gpio_evt_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .stb     (stb),
    .rdSel   (rdSel)
  );

  gpio_evt_detect #(.WIDTH(WIDTH)) u_detect (
    .clk      (clk),
    .rstN     (rstN),
    .dataIn   (dataIn),
    .modeQ    (modeQ),
    .anyEdgeQ (anyEdgeQ),
    .hitVec   (hitVec)
  );

  gpio_evt_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .rdSel    (rdSel),
    .wrData   (regWrData),
    .hitVec   (hitVec),
    .modeQ    (modeQ),
    .anyEdgeQ (anyEdgeQ),
    .rdData   (regRdData),
    .irqOut   (irqOut)
  );

endmodule

// File: tb/gpio_evt_top_tb.sv
module gpio_evt_top_tb;

  localparam logic [6:0] A_MODE = 7'h28;
  localparam logic [6:0] A_ANY  = 7'h2C;
  localparam logic [6:0] A_MASK = 7'h40;
  localparam logic [6:0] A_MSET = 7'h44;
  localparam logic [6:0] A_MCLR = 7'h48;
  localparam logic [6:0] A_STAT = 7'h4C;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] dataIn = '0;
  logic        regWrEn = 1'b0;
  logic [6:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        irqOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gpio_evt_top u_dut (
    .clk       (clk),
    .rstN      (rstN),
    .dataIn    (dataIn),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .irqOut    (irqOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk); #1;
    regWrEn = 1'b0;
  endtask

  task automatic rdChk(input string req, input logic [6:0] a, input logic [31:0] exp);
    @(negedge clk);
    regAddr = a; #1;
    chk(req, regRdData, exp);
  endtask

  task automatic irqChk(input string req, input logic exp);
    @(negedge clk); #1;
    chk(req, {31'd0, irqOut}, {31'd0, exp});
  endtask

  task automatic drive(input logic [31:0] v);
    @(negedge clk);
    dataIn = v;
    @(posedge clk); #1;
  endtask

  task automatic t_reset;
    rdChk("R1", A_MODE, 32'h0);
    rdChk("R1", A_ANY,  32'h0);
    rdChk("R1", A_MASK, 32'h0);
    rdChk("R1", A_STAT, 32'h0);
    irqChk("R1", 1'b0);
  endtask

  task automatic t_regs;
    wr(A_MODE, 32'h0F0F_1234);
    wr(A_ANY,  32'hABCD_0001);
    rdChk("R9 mode readback", A_MODE, 32'h0F0F_1234);
    rdChk("R9 anyedge readback", A_ANY, 32'hABCD_0001);
    wr(7'h00, 32'hFFFF_FFFF);
    wr(7'h04, 32'hFFFF_FFFF);
    rdChk("R9 unmapped read", 7'h00, 32'h0);
    rdChk("R9 unmapped write mode", A_MODE, 32'h0F0F_1234);
    rdChk("R9 unmapped write mask", A_MASK, 32'h0);
    rdChk("R9 unmapped write stat", A_STAT, 32'h0);
    wr(A_MODE, 32'h0);
    wr(A_ANY, 32'h0);
  endtask

  task automatic t_level;
    wr(A_MODE, 32'h0);
    drive(32'hBA98_7654);
    rdChk("R2 level set", A_STAT, 32'hBA98_7654);
    drive(32'h0);
    rdChk("R2 sticky", A_STAT, 32'hBA98_7654);
    wr(A_STAT, 32'h0000_7654);
    rdChk("R5 partial clear", A_STAT, 32'hBA98_0000);
    wr(A_STAT, 32'hBA98_0000);
    rdChk("R5 full clear", A_STAT, 32'h0);
    drive(32'h0000_0001);
    wr(A_STAT, 32'h0000_0001);
    rdChk("R6 detect wins", A_STAT, 32'h0000_0001);
    drive(32'h0);
    wr(A_STAT, 32'hFFFF_FFFF);
    rdChk("R6 clear after drop", A_STAT, 32'h0);
  endtask

  task automatic t_rising;
    drive(32'hFFFF_0000);
    wr(A_MODE, 32'hFFFF_FFFF);
    wr(A_ANY, 32'h0);
    wr(A_STAT, 32'hFFFF_FFFF);
    rdChk("R10 no spurious edge", A_STAT, 32'h0);
    drive(32'hFF00_FF00);
    rdChk("R3 rising only", A_STAT, 32'h0000_FF00);
    drive(32'h00FF_0000);
    rdChk("R3 second rise", A_STAT, 32'h00FF_FF00);
    wr(A_STAT, 32'hFFFF_FFFF);
    rdChk("R5 clear edges", A_STAT, 32'h0);
  endtask

  task automatic t_both;
    drive(32'hFFFF_0000);
    wr(A_MODE, 32'hFFFF_FFFF);
    wr(A_ANY, 32'hFFFF_FFFF);
    wr(A_STAT, 32'hFFFF_FFFF);
    rdChk("R10 steady any-edge", A_STAT, 32'h0);
    drive(32'hFF00_FF00);
    rdChk("R4 both edges", A_STAT, 32'h00FF_FF00);
    drive(32'hEF00_FF08);
    rdChk("R4 fall and rise", A_STAT, 32'h10FF_FF08);
    wr(A_STAT, 32'h0000_F000);
    rdChk("R5 partial clear edges", A_STAT, 32'h10FF_0F08);
    wr(A_STAT, 32'hFFFF_FFFF);
    wr(A_MODE, 32'h0);
    wr(A_ANY, 32'h0);
    drive(32'h0);
    wr(A_STAT, 32'hFFFF_FFFF);
  endtask

  task automatic t_irq;
    wr(A_MASK, 32'h0);
    drive(32'h0000_8000);
    rdChk("R7 status pending", A_STAT, 32'h0000_8000);
    irqChk("R7 masked", 1'b0);
    wr(A_MASK, 32'hFFFF_FFFF);
    irqChk("R7 unmasked", 1'b1);
    drive(32'h0);
    irqChk("R7 input drop keeps irq", 1'b1);
    drive(32'h0000_0200);
    wr(A_STAT, 32'h0000_8000);
    irqChk("R7 other bit keeps irq", 1'b1);
    wr(A_MCLR, 32'h0000_0200);
    rdChk("R8 clear alias", A_MCLR, 32'hFFFF_FDFF);
    irqChk("R8 masked by clear", 1'b0);
    wr(A_MSET, 32'h0000_0200);
    rdChk("R8 set alias", A_MSET, 32'hFFFF_FFFF);
    irqChk("R8 unmasked by set", 1'b1);
    drive(32'h0);
    irqChk("R7 still pending", 1'b1);
    wr(A_STAT, 32'h0000_0200);
    irqChk("R7 drops after clear", 1'b0);
    wr(A_MASK, 32'h0);
    wr(A_MSET, 32'h0000_0005);
    wr(A_MSET, 32'h0000_0030);
    rdChk("R8 set ORs", A_MASK, 32'h0000_0035);
    wr(A_MCLR, 32'h0000_0011);
    rdChk("R8 clear removes", A_MASK, 32'h0000_0024);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_regs();
    t_level();
    t_rising();
    t_both();
    t_irq();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule